// File: doc/BRIEF.md
# Grouped Masked Interrupt Event Aggregator

The block gathers a bank of single-bit hardware event inputs into a set of sticky status words. Each pending bit stays set until software writes a 1 to it. Three independent mask groups sit over the same status words, and each group has its own registered interrupt request line. A line is high while any event that its group enables is pending. The three lines are ordered by priority: index 0 is the most urgent and index 2 the least.

Each line also has a read-only index register. It reports whether that line has an enabled pending event and, if so, the number of the lowest such event. The words are searched from word 0 upward and the bits within each word from bit 0 upward. A handler reads one register to learn which event to service. It then acknowledges that event by writing a 1 to its status bit.

Software reaches all state through a simple register port. Writes take effect on the clock edge. Reads return data in the same cycle, decoded from the address alone.

Top module: `evt_irq_hub`

## Requirements
- R1: After reset every status word and every mask word reads 0, every interrupt line is low, and every index register reads 0.
- R2: A one-cycle pulse on event input n sets bit n mod 32 of the status word at byte offset 4*(n/32). With the default sizing these words are at 0x00, 0x04 and 0x08, and the bit is set at the clock edge that samples the pulse.
- R3: Writing a status word clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: If an event pulse and a write-1 clear hit the same status bit in the same cycle, the bit stays set.
- R5: Mask word k of line g sits at byte offset 0x10*(g+1)+4*k, so line 0 uses 0x10–0x18, line 1 uses 0x20–0x28 and line 2 uses 0x30–0x38. Each mask word is a plain read/write register with bit j aligned to bit j of status word k.
- R6: irq_out[g] equals the OR over all status bits ANDed with line g's mask, as that value stood one clock edge earlier.
- R7: The index register of line g is at offset 0x40+4*g. Bit 31 is set when line g has any enabled pending event, and bits 6:0 hold the lowest such event number; the register reads 0 when no such event exists.
- R8: Each line uses only its own mask group. An event enabled in one group raises neither the line nor the index register of another group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_in | input | 96 | One-cycle event pulses, bit n is event n |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address; accesses with the low two bits nonzero are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| irq_out | output | 3 | Registered interrupt lines, index 0 most urgent |

## Verification
The bench builds the hub with its default parameters: three words of 32 events each and three lines. That sizing covers events in every word, including event 95, the last bit of the last word. It also lets the lowest-index search cross from one word to the next. Every offset in the register map is reached at this size, and a pattern in one line's mask can be shown to leave the other two lines untouched.

// File: rtl/evt_irq_pkg.sv
`timescale 1ns/1ps
// Package: shared decode type for the event aggregator.
// Assumes byte addresses with 16-byte register regions.
package evt_irq_pkg;
    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_MASK   = 2'd1,
        REG_INDEX  = 2'd2,
        REG_NONE   = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/evt_status_bank.sv
`timescale 1ns/1ps
// Module: evt_status_bank
// Holds the sticky pending bits. A bit is set by its event pulse and cleared
// by a write of 1 from software; when both happen in one cycle the set wins.
// Assumes one-hot per-word clear enables supplied by the decoder.
module evt_status_bank #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [WORD_W*NUM_WORDS-1:0]   evt_in,
    input  logic [NUM_WORDS-1:0]          clr_we,
    input  logic [WORD_W-1:0]             clr_bits,
    output logic [WORD_W*NUM_WORDS-1:0]   status_q
);
    genvar k;
    generate
        for (k = 0; k < NUM_WORDS; k++) begin : g_word
            logic [WORD_W-1:0] clr_mask;
            // Select the bits this word clears this cycle.
            always_comb clr_mask = clr_we[k] ? clr_bits : '0;
            // Update the word: clear first, then let new events set.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    status_q[k*WORD_W +: WORD_W] <= '0;
                else
                    status_q[k*WORD_W +: WORD_W] <=
                        (status_q[k*WORD_W +: WORD_W] & ~clr_mask) |
                        evt_in[k*WORD_W +: WORD_W];
            end
        end
    endgenerate
endmodule

// File: rtl/evt_mask_group.sv
`timescale 1ns/1ps
// Module: evt_mask_group
// One line's enable words, plain read/write, cleared by reset.
// Assumes one-hot per-word write enables from the decoder.
module evt_mask_group #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_WORDS-1:0]          wr_we,
    input  logic [WORD_W-1:0]             wr_data,
    output logic [WORD_W*NUM_WORDS-1:0]   mask_q
);
    genvar k;
    generate
        for (k = 0; k < NUM_WORDS; k++) begin : g_word
            // Store the written word when selected.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mask_q[k*WORD_W +: WORD_W] <= '0;
                else if (wr_we[k])
                    mask_q[k*WORD_W +: WORD_W] <= wr_data;
            end
        end
    endgenerate
endmodule

// File: rtl/evt_lowest_find.sv
`timescale 1ns/1ps
// Module: evt_lowest_find
// Combinational search for the lowest set bit of a vector.
// Assumes IDX_W can hold N-1. Output index is 0 when nothing is set.
module evt_lowest_find #(
    parameter int N     = 96,
    parameter int IDX_W = 7
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Walk from the top down so the lowest set bit is the last to write idx.
    always_comb begin
        idx   = '0;
        found = |vec;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/evt_irq_hub.sv
`timescale 1ns/1ps
// Module: evt_irq_hub (top)
// Aggregates event pulses into sticky status words, applies one mask group
// per interrupt line, registers each line and exposes a lowest-pending index
// per line. Register port: writes on the clock edge, reads combinational.
// Assumes word-aligned accesses; misaligned ones are ignored.
module evt_irq_hub
    import evt_irq_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 3,
    parameter int NUM_LINES = 3,
    parameter int ADDR_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [WORD_W*NUM_WORDS-1:0]   evt_in,
    input  logic                          bus_we,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [WORD_W-1:0]             bus_wdata,
    output logic [WORD_W-1:0]             bus_rdata,
    output logic [NUM_LINES-1:0]          irq_out
);
    localparam int NUM_EVT  = WORD_W * NUM_WORDS;
    localparam int IDX_W    = $clog2(NUM_EVT);
    localparam int REGION   = NUM_LINES + 1;
    localparam int PAD_W    = WORD_W - 1 - IDX_W;

    logic [NUM_EVT-1:0]            status_q;
    logic [NUM_EVT-1:0]            mask_q   [NUM_LINES];
    logic [NUM_LINES-1:0]          pend_any;
    logic [NUM_LINES-1:0]          idx_valid;
    logic [IDX_W-1:0]              idx_val  [NUM_LINES];
    logic [NUM_WORDS-1:0]          stat_we;
    logic [NUM_WORDS-1:0]          mask_we  [NUM_LINES];

    reg_kind_e                     kind;
    int                            region;
    int                            wsel;
    logic                          aligned;

    // Split the address into region, word and alignment.
    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        region  = int'(bus_addr[ADDR_W-1:4]);
        wsel    = int'(bus_addr[3:2]);
        if (!aligned)
            kind = REG_NONE;
        else if (region == 0)
            kind = REG_STATUS;
        else if (region <= NUM_LINES)
            kind = REG_MASK;
        else if (region == REGION)
            kind = REG_INDEX;
        else
            kind = REG_NONE;
    end

    // Per-word write-one-to-clear strobes for the status bank.
    always_comb begin
        for (int k = 0; k < NUM_WORDS; k++)
            stat_we[k] = bus_we && (kind == REG_STATUS) && (wsel == k);
    end

    evt_status_bank #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_in   (evt_in),
        .clr_we   (stat_we),
        .clr_bits (bus_wdata),
        .status_q (status_q)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_line
            // Word strobes for this line's mask group.
            always_comb begin
                for (int k = 0; k < NUM_WORDS; k++)
                    mask_we[g][k] = bus_we && (kind == REG_MASK) &&
                                    (region == g + 1) && (wsel == k);
            end

            evt_mask_group #(
                .WORD_W    (WORD_W),
                .NUM_WORDS (NUM_WORDS)
            ) u_mask (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_we   (mask_we[g]),
                .wr_data (bus_wdata),
                .mask_q  (mask_q[g])
            );

            logic [NUM_EVT-1:0] masked;
            // Pending events this line cares about.
            always_comb begin
                masked      = status_q & mask_q[g];
                pend_any[g] = |masked;
            end

            evt_lowest_find #(
                .N     (NUM_EVT),
                .IDX_W (IDX_W)
            ) u_find (
                .vec   (masked),
                .found (idx_valid[g]),
                .idx   (idx_val[g])
            );

            // Register the line so it follows state one edge later.
            always_ff @(posedge clk) begin
                if (!rst_n) irq_out[g] <= 1'b0;
                else        irq_out[g] <= pend_any[g];
            end
        end
    endgenerate

    // Read mux over status, mask and index registers.
    always_comb begin
        bus_rdata = '0;
        case (kind)
            REG_STATUS: if (wsel < NUM_WORDS)
                bus_rdata = status_q[wsel*WORD_W +: WORD_W];
            REG_MASK: begin
                for (int l = 0; l < NUM_LINES; l++)
                    if (region == l + 1 && wsel < NUM_WORDS)
                        bus_rdata = mask_q[l][wsel*WORD_W +: WORD_W];
            end
            REG_INDEX: begin
                for (int l = 0; l < NUM_LINES; l++)
                    if (wsel == l)
                        bus_rdata = {idx_valid[l], {PAD_W{1'b0}}, idx_val[l]};
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/evt_irq_hub_chk.sv
`timescale 1ns/1ps
// Module: evt_irq_hub_chk
// Temporal checks on the aggregator, attached to every hub instance by bind.
module evt_irq_hub_chk #(
    parameter int NUM_EVT   = 96,
    parameter int NUM_LINES = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_EVT-1:0]    evt_in,
    input logic                  bus_we,
    input logic [NUM_EVT-1:0]    status_q,
    input logic [NUM_LINES-1:0]  pend_any,
    input logic [NUM_LINES-1:0]  idx_valid,
    input logic [NUM_LINES-1:0]  irq_out
);
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_in) |=> ((status_q & $past(evt_in)) == $past(evt_in))); // R4
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_in)) == '0)); // R2
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && evt_in == '0) |=> $stable(status_q)); // R3
    AST_IRQ_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(pend_any))); // R6
    AST_INDEX_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        idx_valid == pend_any); // R7
endmodule

bind evt_irq_hub evt_irq_hub_chk #(
    .NUM_EVT   (WORD_W*NUM_WORDS),
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_in    (evt_in),
    .bus_we    (bus_we),
    .status_q  (status_q),
    .pend_any  (pend_any),
    .idx_valid (idx_valid),
    .irq_out   (irq_out)
);

// File: tb/evt_irq_hub_test.sv
`timescale 1ns/1ps
// Directed bench for evt_irq_hub, one task per scenario.
module evt_irq_hub_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] evt_in = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    evt_irq_hub uut (
        .clk (clk), .rst_n (rst_n), .evt_in (evt_in), .bus_we (bus_we),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .irq_out (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input int n);
        @(negedge clk);
        evt_in[n] = 1'b1;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 'h4C; a += 4) begin
            rd(8'(a), d);
            check($sformatf("R1 reg %0h", a), d, 32'h0);
        end
        check("R1 irq", {29'b0, irq_out}, 32'h0);
    endtask

    task automatic t_set_map();
        logic [31:0] d;
        pulse(37);
        rd(8'h04, d); check("R2 event 37", d, 32'h20);
        rd(8'h00, d); check("R2 word0 untouched", d, 32'h0);
        pulse(95);
        rd(8'h08, d); check("R2 event 95", d, 32'h8000_0000);
        pulse(0);
        rd(8'h00, d); check("R2 event 0", d, 32'h1);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(8'h04, 32'h0);
        rd(8'h04, d); check("R3 write zero keeps", d, 32'h20);
        wr(8'h04, 32'h20);
        rd(8'h04, d); check("R3 write one clears", d, 32'h0);
        wr(8'h08, 32'h7FFF_FFFF);
        rd(8'h08, d); check("R3 only written ones clear", d, 32'h8000_0000);
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h00, 32'h1);
        rd(8'h08, d); check("R3 word2 cleared", d, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        pulse(3);
        @(negedge clk);
        evt_in[3] = 1'b1; bus_we = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h8;
        @(negedge clk);
        evt_in = '0; bus_we = 1'b0;
        rd(8'h00, d); check("R4 set beats clear", d, 32'h8);
        wr(8'h00, 32'h8);
        rd(8'h00, d); check("R4 later clear works", d, 32'h0);
    endtask

    task automatic t_mask_rw();
        logic [31:0] d;
        wr(8'h24, 32'hA5A5_0F0F);
        wr(8'h38, 32'h1234_5678);
        rd(8'h24, d); check("R5 mask line1 word1", d, 32'hA5A5_0F0F);
        rd(8'h38, d); check("R5 mask line2 word2", d, 32'h1234_5678);
        rd(8'h14, d); check("R5 mask line0 word1 untouched", d, 32'h0);
        check("R5 no irq without pending", {29'b0, irq_out}, 32'h0);
        wr(8'h24, 32'h0);
        wr(8'h38, 32'h0);
        rd(8'h24, d); check("R5 mask cleared", d, 32'h0);
    endtask

    task automatic t_irq();
        wr(8'h14, 32'h20);
        pulse(37);
        check("R6 irq waits one edge", {29'b0, irq_out}, 32'h0);
        @(negedge clk);
        check("R6 line0 high", {29'b0, irq_out}, 32'h1);
        wr(8'h04, 32'h20);
        check("R6 line0 still high after clear edge", {29'b0, irq_out}, 32'h1);
        @(negedge clk);
        check("R6 line0 low", {29'b0, irq_out}, 32'h0);
        wr(8'h14, 32'h0);
    endtask

    task automatic t_lowest();
        logic [31:0] d;
        wr(8'h20, 32'h400);
        wr(8'h28, 32'h4);
        wr(8'h38, 32'h4);
        pulse(66);
        pulse(70);
        pulse(10);
        @(negedge clk);
        check("R8 lines", {29'b0, irq_out}, 32'h6);
        rd(8'h40, d); check("R8 line0 index empty", d, 32'h0);
        rd(8'h44, d); check("R7 line1 lowest 10", d, 32'h8000_000A);
        rd(8'h48, d); check("R7 line2 lowest 66", d, 32'h8000_0042);
        wr(8'h00, 32'h400);
        rd(8'h44, d); check("R7 line1 moves to 66", d, 32'h8000_0042);
        wr(8'h08, 32'h44);
        rd(8'h44, d); check("R7 line1 empty", d, 32'h0);
        rd(8'h48, d); check("R7 line2 empty", d, 32'h0);
        @(negedge clk);
        check("R6 lines drop", {29'b0, irq_out}, 32'h0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set_map();
        t_clear();
        t_collision();
        t_mask_rw();
        t_irq();
        t_lowest();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule